// File: doc/BRIEF.md
# Cipher State and Key Buffer Controller

This block is the software-facing front end of a block-cipher accelerator. It holds a state buffer and a key buffer, each NBYTES bytes wide. Software fills both buffers one byte per access through two data registers, then requests an operation by setting a go bit in the control register. The cipher datapath itself sits outside the block. It sees both buffers as flat parallel buses, receives a one-cycle start pulse, and answers with a done pulse and a parallel result. On done, the result is loaded back into the state buffer.

The block counts every byte access to the state and key registers, modulo NBYTES. An operation may start only when that count is a multiple of NBYTES. A start request at any other count is refused and sets the error flag. Any touch of the control register while an operation is running also sets the error flag. A ready flag marks a valid result and also serves as the interrupt and DMA request line. It clears itself when software reads the first result byte.

Top module: `cipher_buf_ctrl`

## Requirements
- R1: Register select 0 is control (go bit 7), 1 is status (error bit 7, ready bit 0, bits 6..1 read zero), 2 is state data and 3 is key data. After reset every register, flag and output is zero.
- R2: Each buffer has its own byte pointer. Writes and reads of that buffer share the pointer, which advances by one per access and wraps from NBYTES-1 to 0. Byte i appears on bits [8i+7:8i] of dp_state or dp_key.
- R3: Writing control with bit 7 set while idle, with the access count a multiple of NBYTES, is accepted. The go bit reads 1, dp_start is high for exactly the one cycle after the write, and both pointers return to 0.
- R4: A start request made when the access count is not a multiple of NBYTES sets the error flag. The go bit stays 0 and no dp_start pulse is issued.
- R5: Any read or write of the control register while go is 1 sets the error flag. A write in that state does not change go.
- R6: While go is 1, state-register writes are ignored, state-register reads return zero, and the state buffer and its pointer do not change.
- R7: dp_done while go is 1 loads dp_result into the state buffer, clears go, sets ready in the same cycle, and resets both pointers. dp_done while idle has no effect.
- R8: Ready is cleared by the first state-register read after completion, or by a status write with bit 0 set. Ready rises only after dp_done.
- R9: The error flag is cleared only by a status write with bit 7 set. A status write with bit 7 clear leaves it unchanged.
- R10: ready_req always equals the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe (takes priority over read) |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the selected register (combinational) |
| ready_req | output | 1 | Ready flag; interrupt and DMA request |
| dp_start | output | 1 | One-cycle start pulse to the datapath |
| dp_state | output | NBYTES*DW | State buffer contents |
| dp_key | output | NBYTES*DW | Key buffer contents |
| dp_done | input | 1 | Completion pulse from the datapath |
| dp_result | input | NBYTES*DW | Result loaded into the state buffer on done |

## Verification
The bench builds the block with its defaults, NBYTES = 16 and DW = 8. With these values, a full buffer load, the pointer wrap from 15 to 0 and the count-modulo-16 start rule can all be reached in a few dozen accesses. A bench datapath model answers each start after a fixed latency. That latency is long enough for a sequence of illegal accesses during the busy window to be driven and checked. A misaligned start is followed by top-up writes, so both the refused and the accepted outcome are seen from the same counter.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_STATE = 2'd2,
        SEL_KEY   = 2'd3
    } reg_sel_e;

    localparam int GO_BIT  = 7;
    localparam int ERR_BIT = 7;
    localparam int RDY_BIT = 0;

    typedef struct packed {
        logic ctrl_wr;
        logic ctrl_rd;
        logic stat_wr;
        logic st_wr;
        logic st_rd;
        logic key_wr;
        logic key_rd;
    } acc_t;

    function automatic acc_t decode_access(logic [1:0] sel, logic wr, logic rd);
        acc_t a;
        logic rd_only;
        rd_only   = rd && !wr;
        a.ctrl_wr = wr      && (sel == SEL_CTRL);
        a.ctrl_rd = rd_only && (sel == SEL_CTRL);
        a.stat_wr = wr      && (sel == SEL_STAT);
        a.st_wr   = wr      && (sel == SEL_STATE);
        a.st_rd   = rd_only && (sel == SEL_STATE);
        a.key_wr  = wr      && (sel == SEL_KEY);
        a.key_rd  = rd_only && (sel == SEL_KEY);
        return a;
    endfunction

endpackage

// File: rtl/cbc_byte_buf.sv
module cbc_byte_buf #(
    parameter int NBYTES = 16,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic                 ptr_clr,
    input  logic                 load_en,
    input  logic [NBYTES*DW-1:0] load_data,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rd_byte,
    output logic [NBYTES*DW-1:0] flat
);
    localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

    logic [DW-1:0] mem [NBYTES];
    logic [PW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
        end else if (load_en) begin
            ptr <= '0;
            for (int i = 0; i < NBYTES; i++) mem[i] <= load_data[i*DW +: DW];
        end else begin
            if (wr_en) mem[ptr] <= wdata;
            if (ptr_clr)               ptr <= '0;
            else if (wr_en || rd_en)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    assign rd_byte = mem[ptr];

    for (genvar g = 0; g < NBYTES; g++) begin : g_flat
        assign flat[g*DW +: DW] = mem[g];
    end

    // R2: pointer wraps from the last byte to byte 0
    assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_en) && !ptr_clr && !load_en && ptr == LAST) |=> ptr == '0);

    // R6: with no access, clear or load, pointer holds
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rd_en && !ptr_clr && !load_en) |=> $stable(ptr));

endmodule

// File: rtl/cbc_acc_count.sv
module cbc_acc_count #(
    parameter int MOD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic clr,
    output logic aligned
);
    localparam int CW = (MOD > 1) ? $clog2(MOD) : 1;
    localparam logic [CW-1:0] TOP = CW'(MOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
    end

    assign aligned = (cnt == '0);

    // R3: an accepted start leaves the count aligned
    assert_clr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> aligned);

    // R4: one access from an aligned count makes it misaligned
    assert_step_misaligned_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && aligned) |=> !aligned);

endmodule

// File: rtl/cipher_buf_ctrl.sv
module cipher_buf_ctrl
    import cbc_pkg::*;
#(
    parameter int NBYTES = 16,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           reg_sel,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 ready_req,
    output logic                 dp_start,
    output logic [NBYTES*DW-1:0] dp_state,
    output logic [NBYTES*DW-1:0] dp_key,
    input  logic                 dp_done,
    input  logic [NBYTES*DW-1:0] dp_result
);
    acc_t acc;
    logic go, ready, err;
    logic aligned;
    logic start_req, accept, bad_start, ctrl_busy, done_ok;
    logic st_wr_eff, st_rd_eff, count_inc;
    logic [DW-1:0] st_byte, key_byte;

    assign acc       = decode_access(reg_sel, reg_wr, reg_rd);
    assign start_req = acc.ctrl_wr && reg_wdata[GO_BIT] && !go;
    assign accept    = start_req && aligned;
    assign bad_start = start_req && !aligned;
    assign ctrl_busy = (acc.ctrl_wr || acc.ctrl_rd) && go;
    assign done_ok   = dp_done && go;
    assign st_wr_eff = acc.st_wr && !go;
    assign st_rd_eff = acc.st_rd && !go;
    assign count_inc = st_wr_eff || st_rd_eff || acc.key_wr || acc.key_rd;

    cbc_acc_count #(.MOD(NBYTES)) u_count (
        .clk(clk), .rst(rst), .inc(count_inc), .clr(accept), .aligned(aligned)
    );

    cbc_byte_buf #(.NBYTES(NBYTES), .DW(DW)) u_state (
        .clk(clk), .rst(rst), .wr_en(st_wr_eff), .rd_en(st_rd_eff),
        .ptr_clr(accept), .load_en(done_ok), .load_data(dp_result),
        .wdata(reg_wdata), .rd_byte(st_byte), .flat(dp_state)
    );

    cbc_byte_buf #(.NBYTES(NBYTES), .DW(DW)) u_key (
        .clk(clk), .rst(rst), .wr_en(acc.key_wr), .rd_en(acc.key_rd),
        .ptr_clr(accept || done_ok), .load_en(1'b0), .load_data('0),
        .wdata(reg_wdata), .rd_byte(key_byte), .flat(dp_key)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            go       <= 1'b0;
            ready    <= 1'b0;
            err      <= 1'b0;
            dp_start <= 1'b0;
        end else begin
            dp_start <= accept;
            if (accept)       go <= 1'b1;
            else if (done_ok) go <= 1'b0;
            if (done_ok)                                          ready <= 1'b1;
            else if (st_rd_eff || (acc.stat_wr && reg_wdata[RDY_BIT])) ready <= 1'b0;
            if (bad_start || ctrl_busy)                           err <= 1'b1;
            else if (acc.stat_wr && reg_wdata[ERR_BIT])           err <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_sel))
            SEL_CTRL:  reg_rdata[GO_BIT] = go;
            SEL_STAT: begin
                reg_rdata[ERR_BIT] = err;
                reg_rdata[RDY_BIT] = ready;
            end
            SEL_STATE: reg_rdata = go ? '0 : st_byte;
            SEL_KEY:   reg_rdata = key_byte;
            default:   reg_rdata = '0;
        endcase
    end

    assign ready_req = ready;

    // R3: accepted start gives one start pulse and a set go bit
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_CTRL && reg_wdata[GO_BIT] && !go && aligned)
        |=> (dp_start && go));

    assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
        dp_start |=> !dp_start);

    // R4: misaligned start is refused
    assert_bad_start_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_CTRL && reg_wdata[GO_BIT] && !go && !aligned)
        |=> (err && !go && !dp_start));

    // R5: control access while busy flags an error
    assert_busy_ctrl_R5: assert property (@(posedge clk) disable iff (rst)
        (go && (reg_wr || reg_rd) && reg_sel == SEL_CTRL) |=> err);

    // R6: state buffer frozen while busy
    assert_busy_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (go && !dp_done) |=> $stable(dp_state));

    // R7: done ends the operation and raises ready together
    assert_done_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (go && dp_done) |=> (ready && !go));

    // R8: ready only rises after a done
    assert_ready_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(dp_done));

endmodule

// File: tb/tb_cipher_buf_ctrl.sv
module tb_cipher_buf_ctrl;
    localparam int NB = 16;
    localparam int DW = 8;
    localparam int LAT = 20;

    logic clk = 1'b0;
    logic rst;
    logic [1:0] reg_sel;
    logic reg_wr, reg_rd;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic ready_req, dp_start, dp_done;
    logic [NB*DW-1:0] dp_state, dp_key, dp_result;

    int checks = 0;
    int errors = 0;
    bit model_en = 1'b1;
    bit finished = 1'b0;

    logic [7:0] st_b  [NB];
    logic [7:0] key_b [NB];

    always #2 clk = ~clk;

    cipher_buf_ctrl #(.NBYTES(NB), .DW(DW)) dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ready_req(ready_req),
        .dp_start(dp_start), .dp_state(dp_state), .dp_key(dp_key),
        .dp_done(dp_done), .dp_result(dp_result)
    );

    // datapath model: result byte = state ^ key ^ 8'h5A
    initial begin
        dp_done = 1'b0;
        dp_result = '0;
        forever begin
            @(negedge clk);
            if (model_en && dp_start) begin
                repeat (LAT) @(negedge clk);
                for (int i = 0; i < NB; i++)
                    dp_result[i*8 +: 8] = dp_state[i*8 +: 8] ^ dp_key[i*8 +: 8] ^ 8'h5A;
                dp_done = 1'b1;
                @(negedge clk);
                dp_done = 1'b0;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!ready_req && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 ready_req after reset", ready_req, 0);
        chk("R1 dp_start after reset", dp_start, 0);
        rd(2'd0, d); chk("R1 control after reset", d, 0);
        rd(2'd1, d); chk("R1 status after reset", d, 0);
        chk("R1 dp_state after reset", int'(dp_state == '0), 1);
    endtask

    task automatic t_full_op();
        logic [7:0] d;
        int bad = 0;
        for (int i = 0; i < NB; i++) begin
            key_b[i] = 8'(i * 17 + 3);
            wr(2'd3, key_b[i]);
        end
        for (int i = 0; i < NB; i++) begin
            st_b[i] = 8'(8'hC0 + i * 5);
            wr(2'd2, st_b[i]);
        end
        chk("R2 dp_key byte 15 position", dp_key[15*8 +: 8], key_b[15]);
        chk("R2 dp_state byte 0 position", dp_state[7:0], st_b[0]);
        wr(2'd0, 8'h80);
        chk("R3 dp_start pulse after accepted start", dp_start, 1);
        @(negedge clk);
        chk("R3 dp_start is one cycle", dp_start, 0);
        rd(2'd1, d); chk("R8 ready low while busy", d, 0);
        wait_ready();
        chk("R7 ready_req set on done", ready_req, 1);
        chk("R10 ready_req mirrors ready", ready_req, 1);
        rd(2'd0, d); chk("R7 go cleared on done", d, 0);
        rd(2'd1, d); chk("R1 status ready bit 0 only", d, 8'h01);
        rd(2'd2, d); chk("R7 result byte 0", d, st_b[0] ^ key_b[0] ^ 8'h5A);
        chk("R8 ready cleared by first state read", ready_req, 0);
        for (int i = 1; i < NB; i++) begin
            rd(2'd2, d);
            if (d != (st_b[i] ^ key_b[i] ^ 8'h5A)) bad++;
        end
        chk("R7 remaining result bytes mismatches", bad, 0);
        for (int i = 0; i < NB; i++) st_b[i] = st_b[i] ^ key_b[i] ^ 8'h5A;
    endtask

    task automatic t_bad_start();
        logic [7:0] d;
        for (int i = 0; i < 3; i++) begin
            st_b[i] = 8'(8'h30 + i);
            wr(2'd2, st_b[i]);
        end
        wr(2'd0, 8'h80);
        chk("R4 no dp_start on misaligned start", dp_start, 0);
        rd(2'd1, d); chk("R4 error set on misaligned start", d, 8'h80);
        rd(2'd0, d); chk("R4 go stays 0", d, 0);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R9 status write 0 keeps error", d, 8'h80);
        wr(2'd1, 8'h80);
        rd(2'd1, d); chk("R9 status write bit7 clears error", d, 0);
    endtask

    task automatic t_busy_op();
        logic [7:0] d;
        int bad = 0;
        for (int i = 3; i < NB; i++) begin
            st_b[i] = 8'(8'h60 + i * 3);
            wr(2'd2, st_b[i]);
        end
        wr(2'd0, 8'h80);
        chk("R3 start accepted after top-up to 16", dp_start, 1);
        wr(2'd2, 8'hEE);
        rd(2'd2, d); chk("R6 state read while busy is zero", d, 0);
        rd(2'd1, d); chk("R6 status clean before control touch", d, 0);
        rd(2'd0, d);
        rd(2'd1, d); chk("R5 control read while busy sets error", d, 8'h80);
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h00);
        rd(2'd1, d); chk("R5 control write while busy sets error", d, 8'h80);
        wait_ready();
        chk("R5 go kept by busy write, done accepted", ready_req, 1);
        wr(2'd1, 8'h81);
        rd(2'd1, d); chk("R8 status write bit0 clears ready", d, 0);
        chk("R10 ready_req low after clear", ready_req, 0);
        for (int i = 0; i < NB; i++) begin
            rd(2'd2, d);
            if (d != (st_b[i] ^ key_b[i] ^ 8'h5A)) bad++;
        end
        chk("R6 busy state write ignored, result intact", bad, 0);
    endtask

    task automatic t_idle_done();
        logic [7:0] d;
        model_en = 1'b0;
        @(negedge clk);
        dp_result = {NB{8'hFF}};
        dp_done = 1'b1;
        @(negedge clk);
        dp_done = 1'b0;
        rd(2'd1, d); chk("R7 done while idle leaves ready low", d, 0);
        chk("R7 done while idle leaves state buffer", dp_state[7:0], st_b[0] ^ key_b[0] ^ 8'h5A);
        model_en = 1'b1;
    endtask

    task automatic t_key_wrap();
        logic [7:0] d;
        int bad = 0;
        for (int i = 0; i < NB; i++) begin
            key_b[i] = 8'(8'h91 ^ (i * 7));
            wr(2'd3, key_b[i]);
        end
        for (int i = 0; i < NB; i++) begin
            rd(2'd3, d);
            if (d != key_b[i]) bad++;
        end
        chk("R2 key pointer wraps and is shared by reads", bad, 0);
        wr(2'd0, 8'h80);
        chk("R3 start accepted after 32 accesses", dp_start, 1);
        wait_ready();
        chk("R7 second done raises ready", ready_req, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_sel = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_op();
        t_bad_start();
        t_busy_op();
        t_idle_done();
        t_key_wrap();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule